// File: doc/BRIEF.md
# Ring access violation checker

This stage judges one write-class (read-modify-write) access against the segment descriptor that governs it. The caller presents the descriptor's three ring brackets, its read and write permits and its bound. It also presents the ring and segment that the access targets, the ring and segment of the running procedure, and the computed word address, and raises a request strobe for one cycle. All checks are evaluated together in one combinational pass. Every violation found lands in its own bit of a mask, rather than the first failure ending the evaluation.

While the checks run, the effective ring of the access is rewritten at fixed points. A missing read permit, or an access into the procedure's own segment, replaces it with the procedure ring before the write-bracket comparison. A missing write permit replaces it once more at the end. One cycle after the request, the stage presents the mask, a single fault strobe and the final ring, together with a valid flag. A fault dispatcher downstream uses the whole mask as the fault's subtype.

Top module: `ring_access_checker`

## Requirements
- R1: While reset is high and on the first cycle after it, `chk_valid_o`, `viol_mask_o` and `fault_o` are zero and `ring_o` is zero.
- R2: `chk_valid_o` is high in exactly the cycle after a cycle with `chk_req_i` high; mask, fault and ring for that request appear in the same cycle.
- R3: Mask bit 0 is set when the ordering R1 <= R2 <= R3 of the descriptor brackets does not hold.
- R4: Mask bit 1 is set when the incoming target ring (before any rewrite) is greater than R2.
- R5: When the read permit is off, the effective ring becomes the procedure ring; if in addition the procedure segment differs from the target segment, mask bit 2 is set.
- R6: When the target segment equals the procedure segment, the effective ring becomes the procedure ring before the write-bracket comparison.
- R7: Mask bit 3 is set when the effective ring after the R5 and R6 rewrites is greater than R1.
- R8: When the write permit is off, mask bit 4 is set and the reported ring is the procedure ring.
- R9: Mask bit 5 is set when address bits 17 down to 4, taken as a 14-bit unsigned value, exceed the bound; address bits 3 to 0 never affect it.
- R10: `fault_o` is high in a valid cycle exactly when at least one mask bit is set; the mask is computed fresh for each request and carries nothing from earlier requests.
- R11: In a cycle after one with no request, `viol_mask_o` and `fault_o` are zero and `ring_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_req_i | input | 1 | Start a check this cycle |
| br_lo_i | input | 3 | Descriptor bracket R1 (write limit) |
| br_mid_i | input | 3 | Descriptor bracket R2 (read limit) |
| br_hi_i | input | 3 | Descriptor bracket R3 |
| rd_perm_i | input | 1 | Descriptor read permit |
| wr_perm_i | input | 1 | Descriptor write permit |
| bound_i | input | 14 | Descriptor bound, in 16-word units |
| tgt_ring_i | input | 3 | Ring of the access before rewriting |
| tgt_seg_i | input | 15 | Segment of the access |
| proc_ring_i | input | 3 | Ring of the running procedure |
| proc_seg_i | input | 15 | Segment of the running procedure |
| addr_i | input | 18 | Computed word address within the segment |
| chk_valid_o | output | 1 | Result valid, one cycle after the request |
| viol_mask_o | output | 6 | Violation mask, bit positions per R3 to R9 |
| fault_o | output | 1 | Access-violation fault strobe |
| ring_o | output | 3 | Effective ring after all rewrites |

## Verification
The ring rewrites and the bracket checks interact in a single evaluation. A rewrite caused by a missing read permit or a same-segment access must feed the write-bracket comparison of R7. The later write-permit rewrite must then override what R7 saw. The sweep varies every bracket, the two rings, both permits and segment equality together, so these cases coincide often. Each vector's full mask and final ring are compared with an arithmetic model. Bound overflow is also made to coincide with ring faults, so that the mask is checked to carry several bits at once.

// File: rtl/ring_chk_pkg.sv
package ring_chk_pkg;

    localparam int RING_W     = 3;
    localparam int SEG_W      = 15;
    localparam int ADDR_W     = 18;
    localparam int PAGE_SHIFT = 4;
    localparam int BOUND_W    = ADDR_W - PAGE_SHIFT;

    // violation mask bit positions (decoded downstream as fault subtype)
    localparam int VB_ORDER     = 0;
    localparam int VB_RD_RANGE  = 1;
    localparam int VB_FOREIGN   = 2;
    localparam int VB_WR_RANGE  = 3;
    localparam int VB_WR_OFF    = 4;
    localparam int VB_BOUND     = 5;
    localparam int VIOL_W       = 6;

    typedef logic [VIOL_W-1:0] viol_t;

    typedef struct packed {
        logic              valid;
        viol_t             mask;
        logic              fault;
        logic [RING_W-1:0] ring;
    } chk_result_t;

    function automatic logic brackets_ordered(
        input logic [RING_W-1:0] lo,
        input logic [RING_W-1:0] mid,
        input logic [RING_W-1:0] hi
    );
        return (lo <= mid) && (mid <= hi);
    endfunction

endpackage

// File: rtl/ring_rewrite_chain.sv
module ring_rewrite_chain
    import ring_chk_pkg::*;
#(
    parameter int RW = RING_W,
    parameter int SW = SEG_W
) (
    input  logic [RW-1:0] br_lo_i,
    input  logic [RW-1:0] br_mid_i,
    input  logic [RW-1:0] br_hi_i,
    input  logic          rd_perm_i,
    input  logic          wr_perm_i,
    input  logic [RW-1:0] tgt_ring_i,
    input  logic [SW-1:0] tgt_seg_i,
    input  logic [RW-1:0] proc_ring_i,
    input  logic [SW-1:0] proc_seg_i,
    output viol_t         viol_o,
    output logic [RW-1:0] ring_o
);
    logic          same_seg;
    logic [RW-1:0] ring_after_rd;
    logic [RW-1:0] ring_before_wr;

    assign same_seg = (tgt_seg_i == proc_seg_i);

    // stage 1: read permit rewrite
    assign ring_after_rd  = rd_perm_i ? tgt_ring_i : proc_ring_i;
    // stage 2: own-segment rewrite ahead of the write bracket
    assign ring_before_wr = same_seg ? proc_ring_i : ring_after_rd;
    // stage 3: write permit rewrite
    assign ring_o         = wr_perm_i ? ring_before_wr : proc_ring_i;

    always_comb begin
        viol_o              = '0;
        viol_o[VB_ORDER]    = !brackets_ordered(br_lo_i, br_mid_i, br_hi_i);
        viol_o[VB_RD_RANGE] = (tgt_ring_i > br_mid_i);
        viol_o[VB_FOREIGN]  = !rd_perm_i && !same_seg;
        viol_o[VB_WR_RANGE] = (ring_before_wr > br_lo_i);
        viol_o[VB_WR_OFF]   = !wr_perm_i;
    end

    // the final ring is always one of the two source rings (R8)
    always_comb begin
        a_r8_ring_source: assert (ring_o == tgt_ring_i || ring_o == proc_ring_i)
            else $error("ring rewrite produced an unknown ring");
    end

endmodule

// File: rtl/bound_eval.sv
module bound_eval
    import ring_chk_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int SHIFT = PAGE_SHIFT,
    localparam int BW   = AW - SHIFT
) (
    input  logic [AW-1:0] addr_i,
    input  logic [BW-1:0] bound_i,
    output logic          over_o
);
    logic [BW-1:0] blk;
    logic          unused_low;

    assign blk        = addr_i[AW-1:SHIFT];
    assign unused_low = ^addr_i[SHIFT-1:0];
    assign over_o     = (blk > bound_i);

endmodule

// File: rtl/ring_access_checker.sv
module ring_access_checker
    import ring_chk_pkg::*;
#(
    parameter int RW    = RING_W,
    parameter int SW    = SEG_W,
    parameter int AW    = ADDR_W,
    parameter int SHIFT = PAGE_SHIFT,
    localparam int BW   = AW - SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_req_i,
    input  logic [RW-1:0]     br_lo_i,
    input  logic [RW-1:0]     br_mid_i,
    input  logic [RW-1:0]     br_hi_i,
    input  logic              rd_perm_i,
    input  logic              wr_perm_i,
    input  logic [BW-1:0]     bound_i,
    input  logic [RW-1:0]     tgt_ring_i,
    input  logic [SW-1:0]     tgt_seg_i,
    input  logic [RW-1:0]     proc_ring_i,
    input  logic [SW-1:0]     proc_seg_i,
    input  logic [AW-1:0]     addr_i,
    output logic              chk_valid_o,
    output logic [VIOL_W-1:0] viol_mask_o,
    output logic              fault_o,
    output logic [RW-1:0]     ring_o
);
    viol_t         ring_viol;
    logic [RW-1:0] ring_next;
    logic          over_bound;
    viol_t         mask_next;

    logic              r_valid;
    viol_t             r_mask;
    logic              r_fault;
    logic [RW-1:0]     r_ring;

    ring_rewrite_chain #(.RW(RW), .SW(SW)) u_rings (
        .br_lo_i    (br_lo_i),
        .br_mid_i   (br_mid_i),
        .br_hi_i    (br_hi_i),
        .rd_perm_i  (rd_perm_i),
        .wr_perm_i  (wr_perm_i),
        .tgt_ring_i (tgt_ring_i),
        .tgt_seg_i  (tgt_seg_i),
        .proc_ring_i(proc_ring_i),
        .proc_seg_i (proc_seg_i),
        .viol_o     (ring_viol),
        .ring_o     (ring_next)
    );

    bound_eval #(.AW(AW), .SHIFT(SHIFT)) u_bound (
        .addr_i (addr_i),
        .bound_i(bound_i),
        .over_o (over_bound)
    );

    always_comb begin
        mask_next           = ring_viol;
        mask_next[VB_BOUND] = over_bound;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_valid <= 1'b0;
            r_mask  <= '0;
            r_fault <= 1'b0;
            r_ring  <= '0;
        end else begin
            r_valid <= chk_req_i;
            if (chk_req_i) begin
                r_mask  <= mask_next;
                r_fault <= |mask_next;
                r_ring  <= ring_next;
            end else begin
                r_mask  <= '0;
                r_fault <= 1'b0;
            end
        end
    end

    assign chk_valid_o = r_valid;
    assign viol_mask_o = r_mask;
    assign fault_o     = r_fault;
    assign ring_o      = r_ring;

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        chk_req_i |=> chk_valid_o)
        else $error("valid missing after request");

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !chk_req_i |=> (viol_mask_o == '0 && !fault_o && $stable(ring_o)))
        else $error("idle cycle disturbed outputs");

    a_r10_fault_mask: assert property (@(posedge clk) disable iff (rst)
        chk_valid_o |-> (fault_o == (viol_mask_o != '0)))
        else $error("fault strobe disagrees with mask");

    a_r8_write_off: assert property (@(posedge clk) disable iff (rst)
        (chk_req_i && !wr_perm_i) |=> (viol_mask_o[VB_WR_OFF] && ring_o == $past(proc_ring_i)))
        else $error("write-off not reported");

    a_r9_bound_ok: assert property (@(posedge clk) disable iff (rst)
        (chk_req_i && addr_i[AW-1:SHIFT] <= bound_i) |=> !viol_mask_o[VB_BOUND])
        else $error("bound bit set inside bound");

endmodule

// File: tb/tb_ring_access_checker.sv
module tb_ring_access_checker;

    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [2:0]  r1, r2, r3, tr, pr;
    logic        rd, wr;
    logic [13:0] bound;
    logic [14:0] ts, ps;
    logic [17:0] addr;
    logic        valid_o, fault_o;
    logic [5:0]  mask_o;
    logic [2:0]  ring_o;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ring_access_checker dut (
        .clk(clk), .rst(rst), .chk_req_i(req),
        .br_lo_i(r1), .br_mid_i(r2), .br_hi_i(r3),
        .rd_perm_i(rd), .wr_perm_i(wr), .bound_i(bound),
        .tgt_ring_i(tr), .tgt_seg_i(ts), .proc_ring_i(pr), .proc_seg_i(ps),
        .addr_i(addr), .chk_valid_o(valid_o), .viol_mask_o(mask_o),
        .fault_o(fault_o), .ring_o(ring_o)
    );

    task automatic check(input string req_id, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req_id, act, exp);
        end
    endtask

    // expected values from the requirement text
    logic [5:0] e_mask;
    logic [2:0] e_ring;
    task automatic model();
        logic [2:0] rg;
        e_mask = '0;
        rg = tr;
        if (!(r1 <= r2 && r2 <= r3)) e_mask[0] = 1'b1;      // R3
        if (tr > r2)                 e_mask[1] = 1'b1;      // R4
        if (!rd) begin                                      // R5
            rg = pr;
            if (ps != ts) e_mask[2] = 1'b1;
        end
        if (ts == ps) rg = pr;                              // R6
        if (rg > r1) e_mask[3] = 1'b1;                      // R7
        if (!wr) begin                                      // R8
            rg = pr;
            e_mask[4] = 1'b1;
        end
        if (addr[17:4] > bound) e_mask[5] = 1'b1;           // R9
        e_ring = rg;
    endtask

    task automatic run_one(input string tag);
        model();
        req = 1'b1;
        @(negedge clk);
        check({tag, " valid R2"}, int'(valid_o), 1);
        check({tag, " mask"}, int'(mask_o), int'(e_mask));
        check({tag, " ring"}, int'(ring_o), int'(e_ring));
        check({tag, " fault R10"}, int'(fault_o), int'(e_mask != 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; req = 1'b0;
        r1 = 0; r2 = 0; r3 = 0; tr = 0; pr = 0; rd = 1; wr = 1;
        bound = 14'h3FFF; ts = 15'h1234; ps = 15'h1234; addr = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(valid_o), 0);
        check("R1 mask in reset", int'(mask_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid", int'(valid_o), 0);
        check("R1 mask", int'(mask_o), 0);
        check("R1 fault", int'(fault_o), 0);
        check("R1 ring", int'(ring_o), 0);

        // sweep of brackets, rings, permits and segment equality (R3..R8)
        for (int idx = 0; idx < 32768; idx++) begin
            logic [14:0] v;
            v  = idx[14:0];
            r1 = v[2:0]; r2 = v[5:3]; r3 = v[8:6];
            tr = v[11:9]; pr = v[14:12];
            rd = v[0] ^ v[4] ^ v[9];
            wr = ~(v[1] & v[7] & v[10]);
            ps = 15'h1234;
            ts = (v[2] ^ v[13]) ? 15'h1234 : ((v[3]) ? 15'h1235 : 15'h5234);
            addr  = {4'h0, v[13:0]};
            bound = (v[5]) ? 14'h0003 : 14'h3FFF;
            run_one("R3-sweep R4 R5 R6 R7 R8 R9");
        end

        // bound edges (R9), low address bits irrelevant
        r1 = 3; r2 = 4; r3 = 5; tr = 2; pr = 2; rd = 1; wr = 1; ts = 15'h7; ps = 15'h7;
        for (int b = 0; b < 4; b++) begin
            logic [13:0] bv;
            bv = (b == 0) ? 14'h0000 : (b == 1) ? 14'h0005 : (b == 2) ? 14'h1000 : 14'h3FFE;
            for (int d = -1; d <= 1; d++) begin
                for (int lo = 0; lo < 16; lo += 15) begin
                    logic [13:0] blk;
                    blk   = bv + 14'(d);
                    bound = bv;
                    addr  = {blk, lo[3:0]};
                    run_one("R9 bound edge");
                end
            end
        end

        // several bits at once: order, ranges, write-off, bound (R10)
        r1 = 5; r2 = 2; r3 = 1; tr = 7; pr = 6; rd = 0; wr = 0;
        ts = 15'h4000; ps = 15'h0000; bound = 14'h0; addr = 18'h3FFFF;
        run_one("R10 all bits");
        check("R10 full mask", int'(mask_o), 6'h3F);

        // idle cycles keep the ring and clear mask/fault (R11)
        begin
            logic [2:0] held;
            held = ring_o;
            req = 1'b0;
            r1 = 0; r2 = 0; r3 = 0; tr = 1; pr = 3; wr = 0;
            @(negedge clk);
            check("R11 valid idle", int'(valid_o), 0);
            check("R11 mask idle", int'(mask_o), 0);
            check("R11 fault idle", int'(fault_o), 0);
            check("R11 ring held", int'(ring_o), int'(held));
            @(negedge clk);
            check("R11 ring held 2", int'(ring_o), int'(held));
        end

        // a clean request after a faulting one starts from an empty mask (R10)
        r1 = 7; r2 = 7; r3 = 7; tr = 1; pr = 1; rd = 1; wr = 1;
        ts = 15'h3; ps = 15'h3; bound = 14'h3FFF; addr = 18'h00010;
        run_one("R10 fresh mask");
        check("R10 clean", int'(mask_o), 0);

        req = 1'b0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule